// File: doc/BRIEF.md
# Three-Tone Correlation Energy Meter

This block measures how much energy a real-valued sample stream carries at three chosen tones. It is used during transmitter calibration to score residual spurious products after a correction setting has been applied. Each accepted sample is multiplied against three complex coefficients taken from an externally preloaded table. The six products are accumulated over a frame, normalised, and squared. The result is then averaged over a programmable number of consecutive frames into a single unsigned energy figure.

A measurement is armed with `start`, which also latches the frame count. The block then waits for a sample flagged with `s_first`, collects whole frames of `2**FRAME_LOG2` samples and divides the summed frame energies by the frame count. The result is reported with a one-cycle `done` pulse.

Samples enter on a valid/ready stream. A sample is taken on every rising edge where `s_valid` and `s_ready` are both high. The source must hold `s_data` and `s_first` stable while `s_valid` is high and `s_ready` is low. `s_ready` is deasserted in three cases:
- while the block is idle;
- for three cycles after each frame, while that frame's energy is folded into the running sum;
- during the final division.

The coefficient table is read combinationally. The block drives `tbl_idx` and expects the matching coefficients on `tbl_coef` in the same cycle.

Top module: `tone_energy_meter`

## Requirements
- R1: `s_ready` is high only while a measurement is collecting samples. After the last sample of a frame that is not the final frame, `s_ready` stays low for exactly three cycles, then rises again.
- R2: `tbl_coef` holds six signed 16-bit lanes. Lane l sits at bits [16l+15:16l] and belongs to tone l/2: even lanes are the real part and odd lanes the imaginary part. For each accepted sample, every lane adds (sample × coefficient) arithmetically shifted right by 15 to its own accumulator. Full-scale inputs (-32768 on both operands) do not overflow.
- R3: `tbl_idx` shows the table index for the sample currently offered. It is 0 when `s_valid` and `s_first` are high. Otherwise it counts accepted samples and wraps from `2**FRAME_LOG2-1` back to 0, so each following frame starts at index 0 without `s_first`.
- R4: At frame end, each accumulator is divided by the frame size with an arithmetic right shift by FRAME_LOG2, which rounds toward minus infinity.
- R5: A frame's energy is the sum of the squares of its six normalised accumulators.
- R6: The reported energy is the sum of the frame energies over `frame_count` frames, divided by `frame_count` with the fraction dropped. A `frame_count` of 0 is treated as 1.
- R7: After `start`, samples offered without `s_first` are accepted and discarded until the first sample flagged with `s_first`.
- R8: A sample with `s_first` arriving mid-frame restarts the current frame. The partial sums are dropped and that sample is taken as index 0.
- R9: `done` is high for exactly one cycle, in the cycle where `energy` first shows the new result. `energy` then holds until the next accepted `start`, which clears it to 0.
- R10: `start` is ignored while a measurement is in progress. It changes neither the frame count in use nor the result.
- R11: After reset, `s_ready`, `done`, `energy` and `tbl_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms a measurement when idle |
| frame_count | input | CNT_W | Frames to average (0 counts as 1), latched on start |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_first | input | 1 | Marks the sample as index 0 of a frame |
| s_data | input | 16 | Signed sample |
| tbl_idx | output | FRAME_LOG2 | Coefficient table index |
| tbl_coef | input | 96 | Six signed 16-bit coefficient lanes for `tbl_idx` |
| done | output | 1 | One-cycle result strobe |
| energy | output | 37+CNT_W | Averaged energy |

## Verification
The hardest situations to reach are the ones where the stream does not line up with a clean frame:
- samples arriving before any frame marker;
- a second frame marker landing part-way through a frame;
- a `start` pulse landing while frames are still being collected.

The directed tests build these on purpose. One feeds junk samples before the marked frame. Another sends a marked partial frame followed by a full marked frame. A third raises `start` with a different count after a few samples of a two-frame run. In each case the only accepted outcome is the energy of the clean frames alone.

Rounding toward minus infinity is shown with single non-zero products whose shifted values are negative and not multiples of the frame size.

// File: rtl/tem_pkg.sv
package tem_pkg;
  localparam int SMP_W   = 16;
  localparam int COEF_W  = 16;
  localparam int Q_SHIFT = 15;
  localparam int TONES   = 3;
  localparam int LANES   = 2 * TONES;
  // a shifted product fits in SMP_W+1 signed bits, and so does a normalised sum
  localparam int NRM_W   = SMP_W + 1;
  localparam int SQ_W    = 2 * NRM_W;
  localparam int FE_W    = SQ_W + 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_RUN,
    ST_COMB,
    ST_DIV
  } tem_state_e;
endpackage

// File: rtl/tem_corr.sv
module tem_corr
  import tem_pkg::*;
#(
  parameter int ACC_W = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    restart,
  input  logic signed [SMP_W-1:0] smp,
  input  logic [LANES*COEF_W-1:0] coef,
  output logic [LANES*ACC_W-1:0]  acc_flat
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [COEF_W-1:0]       c;
    logic signed [SMP_W+COEF_W-1:0] prod;
    logic signed [ACC_W-1:0]        term;
    logic signed [ACC_W-1:0]        acc_r;

    assign c    = coef[l*COEF_W +: COEF_W];
    assign prod = smp * c;
    assign term = ACC_W'(prod >>> Q_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_r <= '0;
      else if (clr)     acc_r <= '0;
      else if (en)      acc_r <= (restart ? '0 : acc_r) + term;
    end

    assign acc_flat[l*ACC_W +: ACC_W] = acc_r;
  end
endmodule

// File: rtl/tem_seqdiv.sv
module tem_seqdiv #(
  parameter int NUM_W = 41,
  parameter int DEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic             busy_q;
  logic [CW-1:0]    cnt_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] qsh_q;
  logic             fin_q;
  logic [DEN_W:0]   trial;
  logic             ge;

  assign trial = {rem_q, qsh_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      qsh_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(NUM_W);
        rem_q  <= '0;
        den_q  <= den;
        qsh_q  <= num;
      end else if (busy_q) begin
        rem_q <= ge ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
        qsh_q <= {qsh_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign fin  = fin_q;
  assign quot = qsh_q;

  // R6: the final remainder is below the divisor, so the quotient is truncated
  p_div_rem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < den_q));
endmodule

// File: rtl/tone_energy_meter.sv
module tone_energy_meter
  import tem_pkg::*;
#(
  parameter int FRAME_LOG2 = 10,
  parameter int CNT_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CNT_W-1:0]        frame_count,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic                    s_first,
  input  logic [SMP_W-1:0]        s_data,
  output logic [FRAME_LOG2-1:0]   tbl_idx,
  input  logic [LANES*COEF_W-1:0] tbl_coef,
  output logic                    done,
  output logic [FE_W+CNT_W-1:0]   energy
);
  localparam int ACC_W = NRM_W + FRAME_LOG2;
  localparam int SUM_W = FE_W + CNT_W;

  tem_state_e             state_q;
  logic [FRAME_LOG2-1:0]  idx_q;
  logic [1:0]             k_q;
  logic [CNT_W-1:0]       fcnt_q;
  logic [CNT_W-1:0]       target_q;
  logic [SUM_W-1:0]       sum_q;
  logic [SUM_W-1:0]       energy_q;
  logic                   done_q;

  logic                   go, fire, use_s, frame_end;
  logic [FRAME_LOG2-1:0]  cur_idx;
  logic                   last_comb, last_frame, div_go, clr;
  logic [LANES*ACC_W-1:0] acc_flat;
  logic signed [ACC_W-1:0] a_re, a_im;
  logic signed [NRM_W-1:0] n_re, n_im;
  logic signed [SQ_W-1:0]  sq_re, sq_im;
  logic [SUM_W-1:0]        sum_nxt;
  logic                    div_fin;
  logic [SUM_W-1:0]        quot;

  assign go        = start && (state_q == ST_IDLE);
  assign s_ready   = (state_q == ST_SYNC) || (state_q == ST_RUN);
  assign fire      = s_valid && s_ready;
  assign use_s     = fire && ((state_q == ST_RUN) || s_first);
  assign cur_idx   = (s_valid && s_first) ? '0 : idx_q;
  assign frame_end = use_s && (&cur_idx);
  assign tbl_idx   = cur_idx;

  assign last_comb  = (state_q == ST_COMB) && (k_q == 2'd2);
  assign last_frame = (CNT_W'(fcnt_q + 1'b1) == target_q);
  assign div_go     = last_comb && last_frame;
  assign clr        = go || last_comb;

  tem_corr #(.ACC_W(ACC_W)) u_corr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .en       (use_s),
    .restart  (s_first),
    .smp      ($signed(s_data)),
    .coef     (tbl_coef),
    .acc_flat (acc_flat)
  );

  // one tone per combine cycle: normalise both parts, square, add
  always_comb begin
    a_re    = $signed(acc_flat[(2*k_q)*ACC_W +: ACC_W]);
    a_im    = $signed(acc_flat[(2*k_q+1)*ACC_W +: ACC_W]);
    n_re    = NRM_W'(a_re >>> FRAME_LOG2);
    n_im    = NRM_W'(a_im >>> FRAME_LOG2);
    sq_re   = n_re * n_re;
    sq_im   = n_im * n_im;
    sum_nxt = sum_q + SUM_W'($unsigned(sq_re)) + SUM_W'($unsigned(sq_im));
  end

  tem_seqdiv #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (sum_nxt),
    .den   (target_q),
    .fin   (div_fin),
    .quot  (quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      k_q      <= '0;
      fcnt_q   <= '0;
      target_q <= '0;
      sum_q    <= '0;
      energy_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            target_q <= (frame_count == '0) ? CNT_W'(1) : frame_count;
            fcnt_q   <= '0;
            sum_q    <= '0;
            energy_q <= '0;
            idx_q    <= '0;
            state_q  <= ST_SYNC;
          end
        end
        ST_SYNC, ST_RUN: begin
          if (use_s) begin
            idx_q   <= FRAME_LOG2'(cur_idx + 1'b1);
            state_q <= ST_RUN;
            if (frame_end) begin
              k_q     <= '0;
              state_q <= ST_COMB;
            end
          end
        end
        ST_COMB: begin
          sum_q <= sum_nxt;
          k_q   <= 2'(k_q + 1'b1);
          if (k_q == 2'd2) begin
            fcnt_q  <= CNT_W'(fcnt_q + 1'b1);
            state_q <= last_frame ? ST_DIV : ST_RUN;
          end
        end
        ST_DIV: begin
          if (div_fin) begin
            energy_q <= quot;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign energy = energy_q;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_energy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !$past(go)) |-> $stable(energy_q));

  p_idx_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_s && !s_first && (&idx_q)) |=> (idx_q == '0));

  p_fcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= target_q);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != ST_IDLE) |=> $stable(target_q));
endmodule

// File: tb/tone_energy_meter_tb.sv
module tone_energy_meter_tb;
  localparam int FL = 4;
  localparam int N  = 1 << FL;
  localparam int CW = 4;
  localparam int EW = 37 + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] frame_count = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic          s_first = 1'b0;
  logic [15:0]   s_data = '0;
  logic [FL-1:0] tbl_idx;
  logic [95:0]   tbl_coef;
  logic          done;
  logic [EW-1:0] energy;

  int coef_tab [6][N];
  int smp [4][N];
  int checks = 0;
  int errors = 0;
  int idx_bad = 0;
  bit finished = 0;
  longint got_e;
  logic   done_after;
  longint energy_after;

  always #2 clk = ~clk;

  tone_energy_meter #(.FRAME_LOG2(FL), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_count(frame_count),
    .s_valid(s_valid), .s_ready(s_ready), .s_first(s_first), .s_data(s_data),
    .tbl_idx(tbl_idx), .tbl_coef(tbl_coef), .done(done), .energy(energy)
  );

  always_comb begin
    for (int l = 0; l < 6; l++) tbl_coef[l*16 +: 16] = 16'(coef_tab[l][tbl_idx]);
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint frame_e(input int f);
    longint acc [6];
    longint e = 0;
    for (int l = 0; l < 6; l++) begin
      acc[l] = 0;
      for (int i = 0; i < N; i++) acc[l] += (longint'(smp[f][i]) * coef_tab[l][i]) >>> 15;
      e += (acc[l] >>> FL) * (acc[l] >>> FL);
    end
    return e;
  endfunction

  task automatic fill_tab(input int seed);
    for (int l = 0; l < 6; l++)
      for (int i = 0; i < N; i++)
        coef_tab[l][i] = (((i * 37 + l * 91 + seed * 13) % 201) - 100) * 327;
  endtask

  task automatic fill_smp(input int f, input int seed);
    for (int i = 0; i < N; i++) smp[f][i] = (((i * 53 + seed * 29 + f * 7) % 401) - 200) * 163;
  endtask

  task automatic send(input int d, input logic f, input int exp_idx);
    s_valid = 1'b1;
    s_data  = 16'(d);
    s_first = f;
    #1;
    if (tbl_idx !== FL'(exp_idx)) idx_bad++;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    s_first = 1'b0;
  endtask

  task automatic send_frame(input int f, input int lo, input int hi, input logic first);
    for (int i = lo; i < hi; i++) send(smp[f][i], first && (i == 0), i);
  endtask

  task automatic pulse_start(input int cnt);
    frame_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    got_e = longint'(energy);
    @(negedge clk);
    done_after   = done;
    energy_after = longint'(energy);
  endtask

  task automatic t_reset();
    check("R11 s_ready", s_ready, 0);
    check("R11 done", done, 0);
    check("R11 energy", longint'(energy), 0);
    check("R11 tbl_idx", tbl_idx, 0);
  endtask

  task automatic t_basic();
    fill_tab(1); fill_smp(0, 3);
    idx_bad = 0;
    pulse_start(1);
    send_frame(0, 0, N, 1'b1);
    wait_done();
    check("R2 R5 single frame energy", got_e, frame_e(0));
    check("R3 table index sequence", idx_bad, 0);
  endtask

  task automatic t_floor();
    for (int l = 0; l < 6; l++) for (int i = 0; i < N; i++) coef_tab[l][i] = 0;
    for (int i = 0; i < N; i++) smp[0][i] = 0;
    coef_tab[0][0] = 20000; smp[0][0] = -100;  // -62 -> -4
    coef_tab[3][5] = 20000; smp[0][5] = 100;   //  61 ->  3
    pulse_start(1);
    send_frame(0, 0, N, 1'b1);
    wait_done();
    check("R4 floor shifts", got_e, 25);
  endtask

  task automatic t_average();
    int gap = 0;
    fill_tab(2); fill_smp(0, 5); fill_smp(1, 9); fill_smp(2, 11);
    idx_bad = 0;
    pulse_start(3);
    send_frame(0, 0, N, 1'b1);
    while (!s_ready) begin gap++; @(negedge clk); end
    send_frame(1, 0, N, 1'b0);
    send_frame(2, 0, N, 1'b0);
    wait_done();
    check("R1 ready gap after frame", gap, 3);
    check("R3 index wraps between frames", idx_bad, 0);
    check("R6 three-frame average", got_e, (frame_e(0) + frame_e(1) + frame_e(2)) / 3);
  endtask

  task automatic t_zero_count();
    fill_tab(4); fill_smp(0, 17);
    pulse_start(0);
    send_frame(0, 0, N, 1'b1);
    wait_done();
    check("R6 count zero as one", got_e, frame_e(0));
  endtask

  task automatic t_discard();
    fill_tab(6); fill_smp(0, 21);
    pulse_start(1);
    for (int j = 0; j < 5; j++) send(30000 - j * 999, 1'b0, 0);
    send_frame(0, 0, N, 1'b1);
    wait_done();
    check("R7 samples before marker dropped", got_e, frame_e(0));
  endtask

  task automatic t_restart();
    fill_tab(7); fill_smp(0, 23);
    pulse_start(1);
    for (int j = 0; j < 7; j++) send(-25000 + j * 3001, j == 0, j);
    send_frame(0, 0, N, 1'b1);
    wait_done();
    check("R8 mid-frame restart", got_e, frame_e(0));
  endtask

  task automatic t_busy_start();
    fill_tab(8); fill_smp(0, 31); fill_smp(1, 37);
    pulse_start(2);
    send_frame(0, 0, 3, 1'b1);
    pulse_start(1);
    send_frame(0, 3, N, 1'b1);
    send_frame(1, 0, N, 1'b0);
    wait_done();
    check("R10 start while busy ignored", got_e, (frame_e(0) + frame_e(1)) / 2);
  endtask

  task automatic t_done_hold();
    int moved = 0;
    longint held;
    fill_tab(9); fill_smp(0, 41);
    pulse_start(1);
    send_frame(0, 0, N, 1'b1);
    wait_done();
    check("R9 done lasts one cycle", done_after, 0);
    held = energy_after;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      if (longint'(energy) != held || done) moved++;
    end
    check("R9 energy holds", moved + (held != got_e), 0);
    pulse_start(1);
    check("R9 start clears energy", longint'(energy), 0);
    send_frame(0, 0, N, 1'b1);
    wait_done();
  endtask

  task automatic t_full_scale();
    for (int l = 0; l < 6; l++) for (int i = 0; i < N; i++) coef_tab[l][i] = -32768;
    for (int i = 0; i < N; i++) smp[0][i] = -32768;
    pulse_start(1);
    send_frame(0, 0, N, 1'b1);
    wait_done();
    check("R2 full scale no overflow", got_e, 64'd6442450944);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_floor();
    t_average();
    t_zero_count();
    t_discard();
    t_restart();
    t_busy_start();
    t_done_hold();
    t_full_scale();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule